// File: doc/BRIEF.md
# Multi-slot inter-processor mailbox controller

This block lets a local processor and a peer processor pass fixed-length messages to each other. It holds a parameterised set of slots, 32 by default. Each slot keeps a small mode/state register and a buffer of eight 32-bit message words. A second register region tracks per-vector acknowledge interrupts toward the local processor and per-vector doorbell interrupts toward the peer. Software reaches everything over a plain register bus: read data is combinational in the cycle the access is presented, and writes take effect at the next clock edge.

To send a message, software fills a slot's words, moves the slot to the send state, picks an acknowledge style and rings the peer's doorbell bit for that slot. When the peer finishes, it pulses its completion line for the slot. In automatic style the slot goes back to idle quietly. In interrupt style the slot moves to the done state and latches an acknowledge bit, which can raise the local interrupt if that vector is enabled.

Each slot runs a four-state machine with one-hot codes: ST_IDLE (1), ST_SEND (2), ST_RECV (4) and ST_DONE (8). There are three kinds of transition. A software write of a valid one-hot code moves any state to the coded state. A peer completion moves any state to ST_IDLE in automatic style. A peer completion moves any state to ST_DONE in interrupt style. A peer completion takes priority over a software write to the same slot in the same cycle.

Top module: `mbox_ctrl`

## Requirements
- R1: After reset every slot's mode register reads 0x10 (ST_IDLE, style bit 0), every message word reads 0, the acknowledge raw, enable and doorbell registers read 0, and irq_local and peer_irq are low.
- R2: Slot s occupies byte addresses s*0x40 with address bit 12 low. Its mode register is at +0x0 and message word k (k = 0..7) is at +0x4+4k. Every word of every slot stores and returns its own value.
- R3: In the mode register, bits 7:4 hold the one-hot state (0x1 idle, 0x2 send, 0x4 receive, 0x8 done) and bit 0 holds the style (1 automatic, 0 interrupt). All other bits read 0. A write whose bits 7:4 are not one-hot leaves the state unchanged but still updates bit 0.
- R4: A pulse on peer_ack[s] while slot s is in automatic style returns its state to idle on the next cycle and sets no acknowledge raw bit.
- R5: A pulse on peer_ack[s] while slot s is in interrupt style moves its state to done and sets acknowledge raw bit s (read at 0x1400).
- R6: A write to the doorbell register (0x1420) ORs the written bits into the doorbell vector, which drives peer_irq and reads back at 0x1420. peer_ack[s] clears doorbell bit s.
- R7: A write to 0x140C clears each acknowledge raw bit written as one. If a peer set and a clear hit the same bit in the same cycle, the bit ends up set.
- R8: The enable vector is written whole at 0x1404, ones are set through 0x1500, ones are cleared through 0x1504, and it reads back at 0x1404.
- R9: The status register at 0x1408 reads raw AND enable, and irq_local is high exactly when that status is nonzero.
- R10: Unmapped or unaligned addresses read 0, and writes to them change nothing. This includes slot words beyond the eighth, slot indexes at or above the slot count, and the raw register, which is read-only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 13 | Byte address; bit 12 selects the interrupt region |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| peer_ack | input | NUM_SLOTS | Per-slot completion pulses from the peer |
| peer_irq | output | NUM_SLOTS | Doorbell vector toward the peer |
| irq_local | output | 1 | Local acknowledge interrupt |

## Verification
The message buffers are swept with a pattern that encodes both the slot index and the word index, so any aliasing between slots or words shows up as a wrong value. The state field is driven through every valid code in every slot and through a non-one-hot code. This separates a correct hold from a state that is overwritten or decoded wrongly. Peer completions are applied to every slot in each acknowledge style, which tells a quiet return to idle apart from a latched acknowledge. A completion and a clear are also applied to the same bit in the same cycle to expose the wrong priority. The enable vector is driven through whole writes, set-only writes and clear-only writes, with chosen raw patterns, to check the masked status and the interrupt line.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    // Slot state codes; the one-hot encoding is what software writes and reads.
    typedef enum logic [3:0] {
        ST_IDLE = 4'b0001,
        ST_SEND = 4'b0010,
        ST_RECV = 4'b0100,
        ST_DONE = 4'b1000
    } slot_state_e;

    localparam int REG_W  = 32;
    localparam int WSEL_W = 4;   // word selector inside a 0x40 slot window

    // Offsets within the interrupt region
    localparam logic [11:0] OFF_RAW  = 12'h400;
    localparam logic [11:0] OFF_MASK = 12'h404;
    localparam logic [11:0] OFF_STAT = 12'h408;
    localparam logic [11:0] OFF_CLR  = 12'h40C;
    localparam logic [11:0] OFF_DB   = 12'h420;
    localparam logic [11:0] OFF_ENA  = 12'h500;
    localparam logic [11:0] OFF_DIS  = 12'h504;

endpackage

// File: rtl/mbox_slot.sv
module mbox_slot
    import mbox_pkg::*;
#(
    parameter int MSG_WORDS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_we,
    input  logic              data_we,
    input  logic [WSEL_W-1:0] word_sel,
    input  logic [REG_W-1:0]  wdata,
    input  logic              peer_ack,
    output logic [REG_W-1:0]  mode_rd,
    output logic [REG_W-1:0]  data_rd,
    output logic              ack_req
);

    slot_state_e state_q, state_d;
    logic        auto_q;
    logic [REG_W-1:0] words_q [MSG_WORDS];

    // Next-state: peer completion outranks a software write
    always_comb begin
        state_d = state_q;
        if (peer_ack) begin
            state_d = auto_q ? ST_IDLE : ST_DONE;
        end else if (mode_we) begin
            unique case (wdata[7:4])
                4'b0001: state_d = ST_IDLE;
                4'b0010: state_d = ST_SEND;
                4'b0100: state_d = ST_RECV;
                4'b1000: state_d = ST_DONE;
                default: state_d = state_q;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       auto_q <= 1'b0;
        else if (mode_we) auto_q <= wdata[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < MSG_WORDS; k++) words_q[k] <= '0;
        end else if (data_we) begin
            for (int k = 0; k < MSG_WORDS; k++)
                if (word_sel == WSEL_W'(k + 1)) words_q[k] <= wdata;
        end
    end

    // Outputs
    always_comb begin
        mode_rd = {24'b0, state_q, 3'b000, auto_q};
        ack_req = peer_ack & ~auto_q;
        data_rd = '0;
        for (int k = 0; k < MSG_WORDS; k++)
            if (word_sel == WSEL_W'(k + 1)) data_rd = words_q[k];
    end

    AST_STATE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(state_q)); // R3
    AST_BAD_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_we && !peer_ack && !$onehot(wdata[7:4])) |=> $stable(state_q)); // R3
    AST_AUTO_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (peer_ack && auto_q) |=> (state_q == ST_IDLE)); // R4
    AST_IRQ_TO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (peer_ack && !auto_q) |=> (state_q == ST_DONE)); // R5

endmodule

// File: rtl/mbox_irq.sv
module mbox_irq
    import mbox_pkg::*;
#(
    parameter int NVEC = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [11:0]      off,
    input  logic [REG_W-1:0] wdata,
    input  logic [NVEC-1:0]  ack_set,
    input  logic [NVEC-1:0]  db_clr,
    output logic [REG_W-1:0] rdata,
    output logic             irq_local,
    output logic [NVEC-1:0]  db_vec
);

    logic [NVEC-1:0] raw_q, raw_d, en_q, en_d, db_q, db_d, status;
    logic [NVEC-1:0] wv;
    logic wr_mask, wr_clr, wr_db, wr_ena, wr_dis;

    assign wv      = wdata[NVEC-1:0];
    assign wr_mask = wr_en && (off == OFF_MASK);
    assign wr_clr  = wr_en && (off == OFF_CLR);
    assign wr_db   = wr_en && (off == OFF_DB);
    assign wr_ena  = wr_en && (off == OFF_ENA);
    assign wr_dis  = wr_en && (off == OFF_DIS);

    always_comb begin
        raw_d = (raw_q & ~(wr_clr ? wv : '0)) | ack_set;   // set wins
        db_d  = (db_q & ~db_clr) | (wr_db ? wv : '0);
        en_d  = en_q;
        if (wr_mask)     en_d = wv;
        else if (wr_ena) en_d = en_q | wv;
        else if (wr_dis) en_d = en_q & ~wv;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw_q <= '0;
            en_q  <= '0;
            db_q  <= '0;
        end else begin
            raw_q <= raw_d;
            en_q  <= en_d;
            db_q  <= db_d;
        end
    end

    assign status    = raw_q & en_q;
    assign irq_local = |status;
    assign db_vec    = db_q;

    always_comb begin
        case (off)
            OFF_RAW:  rdata = REG_W'(raw_q);
            OFF_MASK: rdata = REG_W'(en_q);
            OFF_STAT: rdata = REG_W'(status);
            OFF_DB:   rdata = REG_W'(db_q);
            default:  rdata = '0;
        endcase
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|ack_set) |=> ((raw_q & $past(ack_set)) == $past(ack_set))); // R7
    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_clr && ack_set == '0) |=> ((raw_q & $past(wv)) == '0)); // R7
    AST_DB_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_db && (|db_clr)) |=> ((db_q & $past(db_clr)) == '0)); // R6
    AST_QUIET_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |-> !irq_local); // R9

endmodule

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
    import mbox_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    parameter int MSG_WORDS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_en,
    input  logic                 bus_we,
    input  logic [12:0]          bus_addr,
    input  logic [REG_W-1:0]     bus_wdata,
    output logic [REG_W-1:0]     bus_rdata,
    input  logic [NUM_SLOTS-1:0] peer_ack,
    output logic [NUM_SLOTS-1:0] peer_irq,
    output logic                 irq_local
);

    localparam int SLOT_BITS = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
    localparam logic [5:0]        SLOT_LIM = 6'(NUM_SLOTS);
    localparam logic [WSEL_W-1:0] WORD_LIM = WSEL_W'(MSG_WORDS);

    logic                 irq_sel, slot_hit, slot_wr;
    logic [5:0]           slot_field;
    logic [SLOT_BITS-1:0] slot_sel;
    logic [WSEL_W-1:0]    word;
    logic [REG_W-1:0]     irq_rdata;
    logic [NUM_SLOTS-1:0] ack_req_v;
    logic [REG_W-1:0]     mode_rd_a [NUM_SLOTS];
    logic [REG_W-1:0]     data_rd_a [NUM_SLOTS];

    assign irq_sel    = bus_addr[12];
    assign slot_field = bus_addr[11:6];
    assign slot_sel   = slot_field[SLOT_BITS-1:0];
    assign word       = bus_addr[5:2];
    assign slot_hit   = !irq_sel && (slot_field < SLOT_LIM) && (bus_addr[1:0] == 2'b00);
    assign slot_wr    = bus_en && bus_we && slot_hit;

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        logic hit_i;
        assign hit_i = slot_wr && (slot_field == 6'(i));
        mbox_slot #(.MSG_WORDS(MSG_WORDS)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .mode_we  (hit_i && (word == '0)),
            .data_we  (hit_i && (word != '0) && (word <= WORD_LIM)),
            .word_sel (word),
            .wdata    (bus_wdata),
            .peer_ack (peer_ack[i]),
            .mode_rd  (mode_rd_a[i]),
            .data_rd  (data_rd_a[i]),
            .ack_req  (ack_req_v[i])
        );
    end

    mbox_irq #(.NVEC(NUM_SLOTS)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bus_en && bus_we && irq_sel),
        .off       (bus_addr[11:0]),
        .wdata     (bus_wdata),
        .ack_set   (ack_req_v),
        .db_clr    (peer_ack),
        .rdata     (irq_rdata),
        .irq_local (irq_local),
        .db_vec    (peer_irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (irq_sel) begin
            bus_rdata = irq_rdata;
        end else if (slot_hit) begin
            if (word == '0)            bus_rdata = mode_rd_a[slot_sel];
            else if (word <= WORD_LIM) bus_rdata = data_rd_a[slot_sel];
        end
    end

endmodule

// File: tb/sim_mbox_ctrl.sv
module sim_mbox_ctrl;

    localparam int NS = 32;
    localparam int NW = 8;
    localparam logic [12:0] IB = 13'h1000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_en = 1'b0, bus_we = 1'b0;
    logic [12:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [NS-1:0] peer_ack = '0, peer_irq;
    logic irq_local;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    mbox_ctrl #(.NUM_SLOTS(NS), .MSG_WORDS(NW)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .peer_ack(peer_ack), .peer_irq(peer_irq), .irq_local(irq_local));

    function automatic logic [12:0] sa(int s, int w);
        return 13'(s * 64 + w * 4);
    endfunction

    function automatic logic [31:0] pat(int s, int w);
        return (32'(s) * 32'h0001_0100) ^ (32'(w) * 32'h11) ^ 32'hA500_0000;
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [12:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [12:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_en = 1'b0;
    endtask

    task automatic pulse(input logic [NS-1:0] v);
        @(negedge clk);
        peer_ack = v;
        @(negedge clk);
        peer_ack = '0;
    endtask

    task automatic summary;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        logic [31:0] d, exp;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        chk({31'b0, irq_local}, 32'h0, "R1 irq_local");
        chk(peer_irq, 32'h0, "R1 peer_irq");
        for (int s = 0; s < NS; s++) begin
            rd(sa(s, 0), d); chk(d, 32'h10, "R1 mode idle");
            for (int w = 1; w <= NW; w++) begin
                rd(sa(s, w), d); chk(d, 32'h0, "R1 word zero");
            end
        end
        rd(IB | 13'h400, d); chk(d, 0, "R1 raw");
        rd(IB | 13'h404, d); chk(d, 0, "R1 enable");
        rd(IB | 13'h420, d); chk(d, 0, "R1 doorbell");

        // R2: buffer sweep, all written first then all read
        for (int s = 0; s < NS; s++)
            for (int w = 1; w <= NW; w++) wr(sa(s, w), pat(s, w));
        for (int s = 0; s < NS; s++)
            for (int w = 1; w <= NW; w++) begin
                rd(sa(s, w), d); chk(d, pat(s, w), "R2 word readback");
            end

        // R3: every state code, style bit, invalid code, ignored bits
        for (int s = 0; s < NS; s++) begin
            for (int k = 0; k < 4; k++) begin
                exp = (32'h10 << k) | 32'(k & 1);
                wr(sa(s, 0), exp);
                rd(sa(s, 0), d); chk(d, exp, "R3 state code");
            end
            wr(sa(s, 0), 32'h30);
            rd(sa(s, 0), d); chk(d, 32'h80, "R3 bad code holds state");
            wr(sa(s, 0), 32'hFFFF_FF21);
            rd(sa(s, 0), d); chk(d, 32'h21, "R3 extra bits read 0");
        end

        // R4: automatic style returns to idle, no raw bit
        for (int s = 0; s < NS; s++) begin
            wr(sa(s, 0), 32'h21);
            pulse(NS'(1) << s);
            rd(sa(s, 0), d); chk(d, 32'h11, "R4 auto idle");
            rd(IB | 13'h400, d); chk(d, 32'h0, "R4 no raw");
        end

        // R5: interrupt style moves to done and accumulates raw
        exp = 0;
        for (int s = 0; s < NS; s++) begin
            wr(sa(s, 0), 32'h20);
            pulse(NS'(1) << s);
            exp |= 32'(1) << s;
            rd(sa(s, 0), d); chk(d, 32'h80, "R5 irq mode done");
            rd(IB | 13'h400, d); chk(d, exp, "R5 raw set");
        end
        // R7: write-one clear
        wr(IB | 13'h40C, 32'hFFFF_0000);
        rd(IB | 13'h400, d); chk(d, 32'h0000_FFFF, "R7 partial clear");
        wr(IB | 13'h40C, 32'hFFFF_FFFF);
        rd(IB | 13'h400, d); chk(d, 32'h0, "R7 full clear");

        // R8 / R9: enable vector and masked status
        wr(IB | 13'h404, 32'h0);
        wr(IB | 13'h500, 32'h0000_F00F);
        rd(IB | 13'h404, d); chk(d, 32'h0000_F00F, "R8 enable set");
        wr(IB | 13'h504, 32'h0000_0003);
        rd(IB | 13'h404, d); chk(d, 32'h0000_F00C, "R8 disable");
        pulse(NS'(32'h104));
        rd(IB | 13'h408, d); chk(d, 32'h4, "R9 status");
        chk({31'b0, irq_local}, 32'h1, "R9 irq high");
        wr(IB | 13'h504, 32'h4);
        rd(IB | 13'h408, d); chk(d, 32'h0, "R9 status masked");
        chk({31'b0, irq_local}, 32'h0, "R9 irq low");
        rd(IB | 13'h400, d); chk(d, 32'h104, "R9 raw kept");
        wr(IB | 13'h404, 32'hFFFF_FFFF);
        rd(IB | 13'h404, d); chk(d, 32'hFFFF_FFFF, "R8 whole write");
        rd(IB | 13'h408, d); chk(d, 32'h104, "R9 status full");
        wr(IB | 13'h40C, 32'h104);
        chk({31'b0, irq_local}, 32'h0, "R9 irq after clear");

        // R7: set and clear in the same cycle
        wr(sa(5, 0), 32'h20);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = IB | 13'h40C; bus_wdata = 32'h20;
        peer_ack = NS'(32'h20);
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0; peer_ack = '0;
        rd(IB | 13'h400, d); chk(d, 32'h20, "R7 set wins");
        wr(IB | 13'h40C, 32'hFFFF_FFFF);

        // R6: doorbell accumulate and peer clear
        exp = 0;
        for (int s = 0; s < NS; s++) begin
            wr(IB | 13'h420, 32'(1) << s);
            exp |= 32'(1) << s;
            chk(peer_irq, exp, "R6 doorbell accumulate");
        end
        rd(IB | 13'h420, d); chk(d, 32'hFFFF_FFFF, "R6 doorbell read");
        pulse(NS'(32'h0000_0001));
        chk(peer_irq, 32'hFFFF_FFFE, "R6 peer clear one");
        pulse('1);
        chk(peer_irq, 32'h0, "R6 peer clear all");
        wr(IB | 13'h40C, 32'hFFFF_FFFF);

        // R10: unmapped and read-only
        wr(IB | 13'h400, 32'hFFFF_FFFF);
        rd(IB | 13'h400, d); chk(d, 32'h0, "R10 raw read-only");
        wr(IB | 13'h600, 32'h1234_5678);
        rd(IB | 13'h600, d); chk(d, 32'h0, "R10 irq hole");
        wr(sa(0, 9), 32'hDEAD_BEEF);
        rd(sa(0, 9), d); chk(d, 32'h0, "R10 word beyond buffer");
        wr(sa(0, 1) | 13'h1, 32'h0BAD_0BAD);
        rd(sa(0, 1) | 13'h1, d); chk(d, 32'h0, "R10 unaligned read");
        rd(13'h0800, d); chk(d, 32'h0, "R10 slot index out of range");
        for (int w = 1; w <= NW; w++) begin
            rd(sa(0, w), d); chk(d, pat(0, w), "R10 buffer untouched");
        end

        done = 1'b1;
        summary();
    end

endmodule